// File: doc/BRIEF.md
# Parallel-prefix binary adder

This block adds two unsigned N-bit operands and a single carry-in. It produces an N-bit sum and a carry-out, and it holds no state: the outputs follow the inputs through combinational logic only. It does not pass the carry from one bit to the next. Each bit position first forms a pair of terms. The first says the position makes a carry on its own (both operand bits set). The second says it passes an arriving carry through (the operand bits differ). A prefix network then combines these pairs with two-input group operators. After log2 N levels of these operators, every position knows whether a carry arrives from the span below it.

The carry-in is folded into the generate term of bit 0, so the tree never needs a separate carry-in level. Each sum bit is the position's pass-through term XOR the carry coming into it. The carry-out is the group generate of the whole word. The width is a parameter and must be a power of two. Use the block wherever an adder is needed whose depth must grow with the logarithm of the width rather than with the width itself. Registers go around it at the boundaries the surrounding pipeline chooses.

Top module: `lca_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^WIDTH for every input combination.
- R2: `cout` equals bit WIDTH of the full-precision sum `a` + `b` + `cin`.
- R3: When both operands have their most significant bit set, `cout` is 1, whatever the lower bits and `cin` are.
- R4: When the operands differ in every bit (`b` is the bitwise complement of `a`), `cout` equals `cin`. `sum` is all ones when `cin` is 0, and all zeros when `cin` is 1.
- R5: When both operands have their most significant bit clear, `cout` is 0, whatever the lower bits and `cin` are.
- R6: `cin` acts as the carry into bit 0. With `a` all ones, `b` zero and `cin` 1, the carry travels the full word: `sum` is 0 and `cout` is 1. With `cin` 0 the same operands give `sum` all ones and `cout` 0.
- R7: The same source gives a correct adder for any power-of-two WIDTH of at least 2. It is checked at WIDTH 8 over every input combination and at WIDTH 32 over random operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach from the ports is a carry that must cross every level of the prefix tree. That happens when the operands differ in every bit position, so the carry-in alone decides the carry-out. Random 32-bit operands almost never produce a complete pass-through run. Directed vectors therefore pair each operand with its exact complement, and also all ones with zero, under both carry-in values. The 8-bit instance is driven with all 131072 combinations, which covers every pass-through, generate and delete pattern at that width.

// File: rtl/lca_pkg.sv
package lca_pkg;

    // Generate / propagate pair describing one bit or one span of bits
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Two-input group operator: combine an upper span with the span just below it
    function automatic gp_t gp_merge(gp_t upper, gp_t lower);
        gp_t res;
        res.g = upper.g | (upper.p & lower.g);
        res.p = upper.p & lower.p;
        return res;
    endfunction

endpackage

// File: rtl/lca_gp_gen.sv
module lca_gp_gen
    import lca_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             cin_i,
    output gp_t  [WIDTH-1:0] leaf_o,
    output logic [WIDTH-1:0] half_sum_o
);

    logic [WIDTH-1:0] gen_d;
    logic [WIDTH-1:0] prop_d;

    always_comb begin
        gen_d  = opa_i & opb_i;
        prop_d = opa_i ^ opb_i;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
            if (i == 0) begin : g_bit0
                // carry-in folded into bit 0 as an extra generate source
                assign leaf_o[i].g = gen_d[i] | (prop_d[i] & cin_i);
                assign leaf_o[i].p = prop_d[i];
            end else begin : g_bitn
                assign leaf_o[i].g = gen_d[i];
                assign leaf_o[i].p = prop_d[i];
            end
        end
    endgenerate

    assign half_sum_o = prop_d;

    // R3
    always_comb begin
        for (int i = 1; i < WIDTH; i++) begin
            if (opa_i[i] && opb_i[i]) begin
                leaf_gen_chk: assert (leaf_o[i].g && !half_sum_o[i]);
            end
        end
    end

endmodule

// File: rtl/lca_prefix_tree.sv
module lca_prefix_tree
    import lca_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gp_t  [WIDTH-1:0] leaf_i,
    output logic [WIDTH-1:0] grp_g_o,
    output logic [WIDTH-1:0] grp_p_o
);

    localparam int LEVELS = $clog2(WIDTH);

    gp_t [WIDTH-1:0] stage_q [LEVELS+1];

    assign stage_q[0] = leaf_i;

    generate
        for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
            localparam int DIST = 1 << lv;
            for (genvar i = 0; i < WIDTH; i++) begin : g_node
                if (i >= DIST) begin : g_op
                    assign stage_q[lv+1][i] = gp_merge(stage_q[lv][i], stage_q[lv][i-DIST]);
                end else begin : g_pass
                    assign stage_q[lv+1][i] = stage_q[lv][i];
                end
            end
        end
        for (genvar i = 0; i < WIDTH; i++) begin : g_out
            assign grp_g_o[i] = stage_q[LEVELS][i].g;
            assign grp_p_o[i] = stage_q[LEVELS][i].p;
        end
    endgenerate

    // R4: a span that passes everything through carries out what enters bit 0
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            if (grp_p_o[i]) begin
                span_prop_chk: assert (grp_g_o[i] == leaf_i[0].g);
            end
        end
    end

endmodule

// File: rtl/lca_sum.sv
module lca_sum #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] half_sum_i,
    input  logic [WIDTH-1:0] grp_g_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH-1:0] carry_in_d;

    always_comb begin
        carry_in_d = {grp_g_i[WIDTH-2:0], cin_i};
        sum_o      = half_sum_i ^ carry_in_d;
        cout_o     = grp_g_i[WIDTH-1];
    end

endmodule

// File: rtl/lca_adder.sv
module lca_adder
    import lca_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int LEVELS = $clog2(WIDTH);

    generate
        if ((WIDTH < 2) || ((1 << LEVELS) != WIDTH)) begin : g_bad_width
            $error("lca_adder: WIDTH must be a power of two, at least 2");
        end
    endgenerate

    gp_t  [WIDTH-1:0] leaf_d;
    logic [WIDTH-1:0] half_sum_d;
    logic [WIDTH-1:0] grp_g_d;
    logic [WIDTH-1:0] grp_p_d;

    lca_gp_gen #(.WIDTH(WIDTH)) gp_gen_i (
        .opa_i      (a),
        .opb_i      (b),
        .cin_i      (cin),
        .leaf_o     (leaf_d),
        .half_sum_o (half_sum_d)
    );

    lca_prefix_tree #(.WIDTH(WIDTH)) tree_i (
        .leaf_i  (leaf_d),
        .grp_g_o (grp_g_d),
        .grp_p_o (grp_p_d)
    );

    lca_sum #(.WIDTH(WIDTH)) sum_i (
        .half_sum_i (half_sum_d),
        .grp_g_i    (grp_g_d),
        .cin_i      (cin),
        .sum_o      (sum),
        .cout_o     (cout)
    );

    // Arithmetic reference used only by the checks below
    logic [WIDTH:0] ref_d;
    assign ref_d = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        // R1
        sum_ref_chk: assert (sum == ref_d[WIDTH-1:0]);
        // R2
        cout_ref_chk: assert (cout == ref_d[WIDTH]);
        // R3
        if (a[WIDTH-1] && b[WIDTH-1]) begin
            msb_gen_chk: assert (cout);
        end
        // R5
        if (!a[WIDTH-1] && !b[WIDTH-1]) begin
            msb_del_chk: assert (!cout);
        end
        // R4
        if ((a ^ b) == {WIDTH{1'b1}}) begin
            all_prop_chk: assert (cout == cin);
        end
    end

endmodule

// File: tb/lca_adder_tb.sv
`timescale 1ns/1ps
module lca_adder_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  a8 = '0, b8 = '0, s8;
    logic        c8 = 1'b0, co8;
    logic [31:0] a32 = '0, b32 = '0, s32;
    logic        c32 = 1'b0, co32;

    lca_adder #(.WIDTH(8)) dut8_i (
        .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8)
    );

    lca_adder #(.WIDTH(32)) dut_i (
        .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32)
    );

    function automatic logic [8:0] exp8(logic [7:0] x, logic [7:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {8'd0, c};
    endfunction

    function automatic logic [32:0] exp32(logic [31:0] x, logic [31:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {32'd0, c};
    endfunction

    task automatic apply8(logic [7:0] x, logic [7:0] y, logic c, string req);
        logic [8:0] e;
        @(posedge clk);
        a8 = x; b8 = y; c8 = c;
        @(negedge clk);
        e = exp8(x, y, c);
        n_chk++;
        if ({co8, s8} !== e) begin
            n_fail++;
            $display("FAIL %s w8 a=%h b=%h cin=%0d got=%h exp=%h", req, x, y, c, {co8, s8}, e);
        end
    endtask

    task automatic apply32(logic [31:0] x, logic [31:0] y, logic c, string req);
        logic [32:0] e;
        @(posedge clk);
        a32 = x; b32 = y; c32 = c;
        @(negedge clk);
        e = exp32(x, y, c);
        n_chk++;
        if ({co32, s32} !== e) begin
            n_fail++;
            $display("FAIL %s w32 a=%h b=%h cin=%0d got=%h exp=%h", req, x, y, c, {co32, s32}, e);
        end
    endtask

    task automatic expect_bit(logic got, logic want, string req);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s cout got=%0d exp=%0d", req, got, want);
        end
    endtask

    initial begin
        logic [31:0] ra, rb;
        void'($urandom(32'd1234));

        // quiet inputs: zero sum, no carry (R1)
        @(negedge clk);
        n_chk++;
        if ({co32, s32} !== 33'd0 || {co8, s8} !== 9'd0) begin
            n_fail++;
            $display("FAIL R1 idle got=%h/%h exp=0/0", {co32, s32}, {co8, s8});
        end

        // R6: full-length carry driven only by cin
        apply32(32'hFFFF_FFFF, 32'h0, 1'b1, "R6");
        expect_bit(co32, 1'b1, "R6");
        apply32(32'hFFFF_FFFF, 32'h0, 1'b0, "R6");
        expect_bit(co32, 1'b0, "R6");
        apply8(8'hFF, 8'h00, 1'b1, "R6");
        apply8(8'h00, 8'hFF, 1'b1, "R6");

        // R4: every bit passes through, cout follows cin
        for (int k = 0; k < 40; k++) begin
            ra = $urandom();
            apply32(ra, ~ra, k[0], "R4");
            expect_bit(co32, k[0], "R4");
        end

        // R3 / R5: msb generate and delete
        for (int k = 0; k < 40; k++) begin
            ra = $urandom(); rb = $urandom();
            apply32(ra | 32'h8000_0000, rb | 32'h8000_0000, k[0], "R3");
            expect_bit(co32, 1'b1, "R3");
            apply32(ra & 32'h7FFF_FFFF, rb & 32'h7FFF_FFFF, k[0], "R5");
            expect_bit(co32, 1'b0, "R5");
        end

        // R7 R1 R2: exhaustive at width 8
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                for (int c = 0; c < 2; c++) begin
                    apply8(i[7:0], j[7:0], c[0], "R7 R1 R2");
                end
            end
        end

        // R7 R1 R2: random at width 32
        for (int k = 0; k < 15000; k++) begin
            apply32($urandom(), $urandom(), 1'($urandom()), "R7 R1 R2");
        end

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule